// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This execution unit serves a 64-bit integer pipeline. It takes one instruction word per cycle together with the two source operand values and a flag that enables 64-bit operation. From these it computes either an extracted, right-justified bit field or an insertion of low source bits into a second operand. The result comes out of a register one clock later. Register-file access, hazards and exception delivery are handled by the surrounding pipeline. The unit only reports that a word is reserved and returns the second operand unchanged.

Two positions drive every operation: a low bit and a high bit. The decoder takes them from two 5-bit instruction fields. The long and upper variants add half the word width (32) to the high end, or to both ends. This lets 5-bit fields name fields that are wider than 32 bits or that start above bit 31. The 32-bit forms sign-extend their result to 64 bits. A one-bit stage machine tracks whether the output register holds a fresh result. The machine has two states, STAGE_EMPTY and STAGE_FULL. The transition ACCEPT goes from EMPTY to FULL when `in_valid` is high. DRAIN goes from FULL to EMPTY when `in_valid` is low. REFILL keeps the machine in FULL when `in_valid` is high. IDLE keeps it in EMPTY when `in_valid` is low. Reset forces STAGE_EMPTY.

Top module: `bfx_unit`

## Requirements
- R1: An instruction belongs to the unit when bits 31:26 equal 011111 and bits 5:3 are 000. Bits 2:0 select the operation: 000 EXT, 001 DEXTM, 010 DEXTU, 011 DEXT, 100 INS, 101 DINSM, 110 DINSU, 111 DINS. The field `a` is bits 15:11 and the field `b` is bits 10:6.
- R2: DEXT returns bits b..b+a of rs in the low bits of the result, with the remaining bits zero.
- R3: DEXTM extracts bits b..b+a+32 of rs. DEXTU extracts bits b+32..b+32+a of rs. Both results are right-justified and zero-filled.
- R4: EXT extracts bits b..b+a of the low 32 bits of rs. It then copies bit 31 of the 32-bit result into result bits 63:32.
- R5: DINS returns rt with bits b..a replaced by the low (a-b+1) bits of rs.
- R6: DINSM replaces bits b..a+32 of rt with low rs bits shifted left by b. DINSU replaces bits b+32..a+32 of rt with low rs bits shifted left by b+32.
- R7: INS performs the insert on bits b..a of the low 32 bits. It then copies bit 31 of the 32-bit result into result bits 63:32.
- R8: When `wide_en` is 0, any of the six 64-bit operations sets `resv_insn` and returns rt unchanged. EXT and INS still execute normally.
- R9: If the high position is below the low position, or above 31 for EXT/INS or above 63 otherwise, the result is rt unchanged and `resv_insn` stays 0.
- R10: A word outside the R1 encoding sets `resv_insn` and returns rt unchanged.
- R11: The result and flag appear exactly one clock after `in_valid`, and `out_valid` follows `in_valid` with one cycle of delay. While `in_valid` is 0, `result` holds its value and `resv_insn` is 0.
- R12: A synchronous active-high reset clears `out_valid`, `resv_insn` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| rs_val | input | 64 | Source operand (field source) |
| rt_val | input | 64 | Second operand (insert target, pass-through value) |
| wide_en | input | 1 | 64-bit operations enabled |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered result |
| resv_insn | output | 1 | Registered reserved-instruction flag |

## Verification
The checker watches every cycle for several properties. These are the one-cycle delay of `out_valid`, a reset that leaves the stage empty, and `resv_insn` being raised only together with `out_valid`. It also checks that a reserved result always equals the rt that was presented one cycle earlier. It confirms that a 64-bit operation with `wide_en` low is always flagged, and that an in-range EXT always yields a sign-extended result. The exact field contents depend on the data, so only the directed scenarios can show them. These cover the shifted bit positions of the long and upper variants and the insert merge against rt. They also cover the out-of-range cases that must return rt without a flag.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    localparam logic [5:0] OPC_BFX = 6'b011111;

    typedef enum logic {
        STAGE_EMPTY,
        STAGE_FULL
    } stage_e;

    typedef struct packed {
        logic known;     // word belongs to this unit
        logic narrow;    // 32-bit form, sign-extended result
        logic do_ins;    // insert rather than extract
        logic in_range;  // high >= low and high within width
        logic resv;      // reserved-instruction condition
    } ctl_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2,
    localparam int FW = $clog2(HALF),
    localparam int PW = $clog2(XLEN) + 2
) (
    input  logic [31:0]   insn,
    input  logic          wide_en,
    output ctl_t          ctl,
    output logic [PW-1:0] lo_pos,
    output logic [PW-1:0] hi_pos
);
    logic [5:0]    func;
    logic [PW-1:0] fa, fb, lim;
    logic [1:0]    sel;

    always_comb begin
        func = insn[5:0];
        sel  = func[1:0];
        fa   = PW'(insn[11+FW-1:11]);
        fb   = PW'(insn[6+FW-1:6]);

        ctl.known  = (insn[31:26] == OPC_BFX) && (func[5:3] == 3'b000);
        ctl.narrow = (sel == 2'b00);
        ctl.do_ins = func[2];

        lo_pos = fb + ((sel == 2'b10) ? PW'(HALF) : PW'(0));
        if (ctl.do_ins)
            hi_pos = fa + ((sel == 2'b01 || sel == 2'b10) ? PW'(HALF) : PW'(0));
        else
            hi_pos = lo_pos + fa + ((sel == 2'b01) ? PW'(HALF) : PW'(0));

        lim          = ctl.narrow ? PW'(HALF - 1) : PW'(XLEN - 1);
        ctl.in_range = (hi_pos >= lo_pos) && (hi_pos <= lim);
        ctl.resv     = !ctl.known || (!ctl.narrow && !wide_en);
    end
endmodule

// File: rtl/bfx_field.sv
module bfx_field #(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2,
    localparam int PW = $clog2(XLEN) + 2
) (
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [PW-1:0]   lo_pos,
    input  logic [PW-1:0]   hi_pos,
    input  logic            do_ins,
    input  logic            narrow,
    output logic [XLEN-1:0] field_out
);
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] core;

    for (genvar i = 0; i < XLEN; i++) begin : g_mask
        assign mask[i] = (PW'(i) >= lo_pos) && (PW'(i) <= hi_pos);
    end

    always_comb begin
        if (do_ins)
            core = rt_val ^ ((rt_val ^ (rs_val << lo_pos)) & mask);
        else
            core = (rs_val & mask) >> lo_pos;
        if (narrow)
            field_out = {{HALF{core[HALF-1]}}, core[HALF-1:0]};
        else
            field_out = core;
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int PW = $clog2(XLEN) + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic            wide_en,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            resv_insn
);
    ctl_t            ctl;
    logic [PW-1:0]   lo_pos, hi_pos;
    logic [XLEN-1:0] field_out;
    stage_e          stage_q, stage_d;
    logic [XLEN-1:0] result_q;
    logic            resv_q;

    bfx_decode #(.XLEN(XLEN)) dec_i (
        .insn(insn), .wide_en(wide_en), .ctl(ctl),
        .lo_pos(lo_pos), .hi_pos(hi_pos)
    );

    bfx_field #(.XLEN(XLEN)) fld_i (
        .rs_val(rs_val), .rt_val(rt_val), .lo_pos(lo_pos), .hi_pos(hi_pos),
        .do_ins(ctl.do_ins), .narrow(ctl.narrow), .field_out(field_out)
    );

    always_comb begin
        unique case (stage_q)
            STAGE_EMPTY: stage_d = in_valid ? STAGE_FULL : STAGE_EMPTY;
            STAGE_FULL:  stage_d = in_valid ? STAGE_FULL : STAGE_EMPTY;
            default:     stage_d = STAGE_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= STAGE_EMPTY;
        else     stage_q <= stage_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            resv_q   <= 1'b0;
        end else begin
            resv_q <= in_valid && ctl.resv;
            if (in_valid)
                result_q <= (ctl.resv || !ctl.in_range) ? rt_val : field_out;
        end
    end

    always_comb begin
        out_valid = (stage_q == STAGE_FULL);
        result    = result_q;
        resv_insn = resv_q;
    end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [31:0]     insn,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic            wide_en,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            resv_insn
);
    logic ours, wide_op, ext_ok;
    always_comb begin
        ours    = (insn[31:26] == 6'b011111) && (insn[5:3] == 3'b000);
        wide_op = ours && (insn[1:0] != 2'b00);
        ext_ok  = ours && (insn[2:0] == 3'b000)
                  && ({1'b0, insn[10:6]} + {1'b0, insn[15:11]} <= 6'd31);
    end

    assert_reset_empty_R12: assert property (@(posedge clk)
        rst |=> !out_valid && !resv_insn);

    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drop_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(result));

    assert_flag_with_valid_R11: assert property (@(posedge clk) disable iff (rst)
        resv_insn |-> out_valid);

    assert_wide_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && wide_op && !wide_en |=> resv_insn && result == $past(rt_val));

    assert_unknown_flag_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && !ours |=> resv_insn && result == $past(rt_val));

    assert_ext_sext_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && ext_ok |=> result[XLEN-1:HALF] == {HALF{result[HALF-1]}});
endmodule

bind bfx_unit bfx_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .rs_val(rs_val), .rt_val(rt_val), .wide_en(wide_en),
    .out_valid(out_valid), .result(result), .resv_insn(resv_insn)
);

// File: tb/bfx_unit_tb_top.sv
module bfx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] rs_val = '0, rt_val = '0;
    logic        wide_en = 1'b1;
    logic        out_valid, resv_insn;
    logic [63:0] result;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    bfx_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .rs_val(rs_val), .rt_val(rt_val), .wide_en(wide_en),
        .out_valid(out_valid), .result(result), .resv_insn(resv_insn)
    );

    function automatic logic [31:0] mk(input logic [5:0] fn, input int a, input int b);
        return {6'b011111, 5'd3, 5'd4, 5'(a), 5'(b), fn};
    endfunction

    // Independent bit-by-bit reference built from the requirements.
    task automatic model(input logic [31:0] w, input logic [63:0] rs, input logic [63:0] rt,
                         input bit wide, output logic [63:0] res, output logic rv);
        int a = int'(w[15:11]);
        int b = int'(w[10:6]);
        int lo = 0, hi = 0, lim = 63;
        bit ins = 0, nar = 0;
        res = rt; rv = 0;
        if (w[31:26] != 6'b011111 || w[5:3] != 3'b000) begin rv = 1; return; end
        case (w[2:0])
            3'd0: begin lo = b;      hi = b + a;      nar = 1; end
            3'd1: begin lo = b;      hi = b + a + 32;          end
            3'd2: begin lo = b + 32; hi = b + 32 + a;          end
            3'd3: begin lo = b;      hi = b + a;               end
            3'd4: begin lo = b;      hi = a;      ins = 1; nar = 1; end
            3'd5: begin lo = b;      hi = a + 32; ins = 1;     end
            3'd6: begin lo = b + 32; hi = a + 32; ins = 1;     end
            default: begin lo = b;   hi = a;      ins = 1;     end
        endcase
        if (nar) lim = 31;
        if (!nar && !wide) begin rv = 1; return; end
        if (hi < lo || hi > lim) return;
        if (ins) begin
            for (int i = lo; i <= hi; i++) res[i] = rs[i - lo];
        end else begin
            res = '0;
            for (int i = 0; i <= hi - lo; i++) res[i] = rs[lo + i];
        end
        if (nar) for (int i = 32; i < 64; i++) res[i] = res[31];
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [31:0] w, input logic [63:0] rs,
                       input logic [63:0] rt, input bit wide);
        logic [63:0] er; logic ev;
        model(w, rs, rt, wide, er, ev);
        @(negedge clk);
        insn = w; rs_val = rs; rt_val = rt; wide_en = wide; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " out_valid"}, 64'(out_valid), 64'd1);
        chk({req, " result"}, result, er);
        chk({req, " resv_insn"}, 64'(resv_insn), 64'(ev));
    endtask

    localparam logic [63:0] PA = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] PB = 64'hF0E1_D2C3_B4A5_9687;

    task automatic t_reset;
        chk("R12 out_valid", 64'(out_valid), 64'd0);
        chk("R12 result", result, 64'd0);
        chk("R12 resv_insn", 64'(resv_insn), 64'd0);
    endtask

    task automatic t_dext;
        run("R1 R2 dext literal", mk(6'b000011, 7, 4), PA, PB, 1);
        chk("R2 dext value", result, 64'hDE);
        run("R2 dext full", mk(6'b000011, 31, 0), PB, PA, 1);
        run("R2 dext high", mk(6'b000011, 0, 31), PA, PB, 1);
    endtask

    task automatic t_dext_mu;
        run("R3 dextm", mk(6'b000001, 31, 0), PB, PA, 1);
        run("R3 dextm mid", mk(6'b000001, 5, 12), PA, PB, 1);
        run("R3 dextu", mk(6'b000010, 31, 0), PB, PA, 1);
        run("R3 dextu mid", mk(6'b000010, 6, 9), PA, PB, 1);
    endtask

    task automatic t_ext;
        run("R4 ext neg", mk(6'b000000, 3, 28), PB, PA, 1);
        run("R4 ext pos", mk(6'b000000, 7, 8), PA, PB, 1);
        run("R4 ext full", mk(6'b000000, 31, 0), 64'h0000_0000_8000_0001, PA, 1);
        chk("R4 ext sext value", result, 64'hFFFF_FFFF_8000_0001);
    endtask

    task automatic t_dins;
        run("R5 dins", mk(6'b000111, 19, 8), PA, PB, 1);
        run("R5 dins single", mk(6'b000111, 0, 0), 64'h1, 64'h0, 1);
        chk("R5 dins bit0", result, 64'h1);
    endtask

    task automatic t_dins_mu;
        run("R6 dinsm", mk(6'b000101, 10, 4), PB, PA, 1);
        run("R6 dinsm wide", mk(6'b000101, 31, 0), PA, 64'h0, 1);
        run("R6 dinsu", mk(6'b000110, 20, 3), PB, PA, 1);
        run("R6 dinsu top", mk(6'b000110, 31, 31), 64'h1, 64'h0, 1);
        chk("R6 dinsu bit63", result, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_ins;
        run("R7 ins neg", mk(6'b000100, 31, 24), PB, PA, 1);
        run("R7 ins pos", mk(6'b000100, 15, 4), PA, PB, 1);
    endtask

    task automatic t_mode;
        run("R8 dext blocked", mk(6'b000011, 7, 4), PA, PB, 0);
        run("R8 dinsu blocked", mk(6'b000110, 20, 3), PA, PB, 0);
        run("R8 ext allowed", mk(6'b000000, 7, 4), PA, PB, 0);
        run("R8 ins allowed", mk(6'b000100, 9, 2), PA, PB, 0);
    endtask

    task automatic t_illegal;
        run("R9 ext over 31", mk(6'b000000, 20, 20), PA, PB, 1);
        run("R9 dextm over 63", mk(6'b000001, 20, 20), PA, PB, 1);
        run("R9 dextu over 63", mk(6'b000010, 5, 30), PA, PB, 1);
        run("R9 dins msb<lsb", mk(6'b000111, 3, 9), PA, PB, 1);
        run("R9 ins msb<lsb", mk(6'b000100, 5, 10), PA, PB, 1);
        run("R9 dinsu msb<lsb", mk(6'b000110, 2, 7), PA, PB, 1);
        chk("R9 dinsu value", result, PB);
    endtask

    task automatic t_unknown;
        run("R10 bad opcode", {6'b011110, mk(6'b000011, 7, 4)[25:0]}, PA, PB, 1);
        run("R10 bad func", mk(6'b001011, 7, 4), PA, PB, 1);
        run("R10 func 100000", mk(6'b100000, 7, 4), PA, PB, 1);
    endtask

    task automatic t_latency;
        logic [63:0] held;
        run("R11 load", mk(6'b000011, 15, 8), PB, PA, 1);
        held = result;
        @(negedge clk);
        chk("R11 valid drops", 64'(out_valid), 64'd0);
        chk("R11 result holds", result, held);
        chk("R11 flag low", 64'(resv_insn), 64'd0);
        @(negedge clk);
        insn = mk(6'b000011, 3, 0); rs_val = 64'hF; in_valid = 1'b1;
        chk("R11 no early update", result, held);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 one-cycle result", result, 64'hF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R11 watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_dext();
        t_dext_mu();
        t_ext();
        t_dins();
        t_dins_mu();
        t_ins();
        t_mode();
        t_illegal();
        t_unknown();
        t_latency();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        t_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule